// File: doc/BRIEF.md
# Write-Only Register Readback Sequencer

This block keeps shadow copies of legacy I/O registers that software can only write: the init and operation command words of a cascaded master/slave interrupt controller, the interval timer's base counts and mode status, and the real-time-clock index register. It watches every write on a simple synchronous I/O bus and decodes each write into the shadow it belongs to, following the interrupt controller's initialization sequence and the timer's byte-access modes. Capture runs all the time, whether or not the readback mode is active.

When the readback mode input is held high, the block serves reads of a small set of ports. A port with several hidden registers behind it steps through a fixed list, one entry per read, through its own access counter. The counter wraps after the last entry, and it returns to the first entry whenever the mode is off. Reserved bits of the interrupt-controller words come back as fixed constants, so firmware can save the state before power-down and restore it afterwards. While the mode is off, or for ports outside the list, the block does not serve the read.

Top module: `io_shadow_readback`

## Requirements
- R1: With readback mode on, successive reads of port 0x20 return 12 entries in this order: master ICW2, ICW3, ICW4, OCW1, OCW2, OCW3, then the same six for the slave. The 13th read returns the first entry again.
- R2: With readback mode on, successive reads of port 0x40 return 7 entries, then wrap: counter 0 status, counter 0 base low, counter 0 base high, counter 1 base low, counter 1 base high, counter 2 base low, counter 2 base high. A status entry is the captured control-word bits [5:0] with bits [7:6] zero.
- R3: With readback mode on, every read of port 0x42 returns counter 2 status (control-word bits [5:0], bits [7:6] zero).
- R4: With readback mode on, a read of port 0x70 returns bit 7 as 0 and bits [6:0] as the last index written to port 0x70.
- R5: Reserved bits read back as constants. ICW2[2:0]=000. ICW4[7:5]=000, ICW4[3:2]=00 and ICW4[0]=0. OCW2[4:3]=00. OCW3[7]=0 and OCW3[4:3]=01. OCW3 bit 5 reads as a copy of OCW3 bit 6.
- R6: The master sits at ports 0x20/0x21 and the slave at 0xA0/0xA1, and each decodes its own writes. An even-port write with bit 4 set is ICW1: it restarts initialization and records whether ICW4 follows (bit 0). The next odd-port writes are ICW2, then ICW3, then ICW4 only if it was requested. After that, odd-port writes are OCW1. An even-port write with bit 4 clear is OCW2 when bit 3 is 0 and OCW3 when bit 3 is 1.
- R7: A write to port 0x43 selects a counter with bits [7:6] (0..2). When bits [5:4] are nonzero, it stores bits [5:0] as that counter's status and access mode and restarts its byte toggle. A write with select 3 or with bits [5:4] = 00 changes no shadow.
- R8: Writes to port 0x40+n set counter n's base count according to access mode bits [5:4]. Mode 01 sets the low byte and clears the high byte. Mode 10 sets the high byte and clears the low byte. Mode 11 writes low, then high, alternately.
- R9: Each served port's access counter advances by one per served read and wraps after its last entry. The counter is held at the first entry whenever readback mode is off.
- R10: With readback mode off, or for a port outside 0x20/0x40/0x42/0x70, `rd_hit` is 0 and `rd_data` is 0. Shadow capture continues while readback mode is on.
- R11: Synchronous active-high reset clears every shadow, every access counter, the init sequence state and the timer access modes to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_mode | input | 1 | Readback mode enable (level) |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_addr | input | AW | I/O port address |
| io_wdata | input | 8 | Write data |
| rd_hit | output | 1 | The block serves this read |
| rd_data | output | 8 | Read data, valid while rd_hit is 1 |

## Verification
Read results are combinational: `rd_hit` and `rd_data` are due in the same cycle the read strobe and address are presented. The bench drives each access just after a falling edge and samples shortly before the next rising edge. A write reaches its shadow at the rising edge that ends its cycle, and a read advances its port counter at that same edge. Each access therefore takes exactly one clock, and the next access observes the updated state. Toggling readback mode takes effect on the following read.

// File: rtl/io_shadow_readback.sv
module io_shadow_readback #(
  parameter int AW = 16,
  parameter logic [AW-1:0] PIC_M = 16'h0020,
  parameter logic [AW-1:0] PIC_S = 16'h00A0,
  parameter logic [AW-1:0] PIT   = 16'h0040,
  parameter logic [AW-1:0] RTC   = 16'h0070
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alt_mode,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [AW-1:0] io_addr,
  input  logic [7:0]    io_wdata,
  output logic          rd_hit,
  output logic [7:0]    rd_data
);

  localparam logic [AW-1:0] ONE = 1;
  localparam logic [AW-1:0] TWO = 2;
  localparam logic [AW-1:0] THREE = 3;
  localparam logic [3:0] PIC_LAST = 4'd11;
  localparam logic [2:0] PIT_LAST = 3'd6;

  // interrupt controller shadows, one per controller
  for (genvar c = 0; c < 2; c++) begin : g_pic
    localparam logic [AW-1:0] BASE = (c == 0) ? PIC_M : PIC_S;
    logic [4:0] icw2;
    logic [7:0] icw3;
    logic [1:0] icw4;
    logic [7:0] ocw1;
    logic [5:0] ocw2;
    logic [3:0] ocw3;
    logic [1:0] ist;
    logic       need4;

    wire wr_even = io_wr && io_addr == BASE;
    wire wr_odd  = io_wr && io_addr == BASE + ONE;

    always_ff @(posedge clk) begin
      if (rst) begin
        icw2 <= '0; icw3 <= '0; icw4 <= '0; ocw1 <= '0;
        ocw2 <= '0; ocw3 <= '0; ist <= '0; need4 <= 1'b0;
      end else if (wr_even && io_wdata[4]) begin
        ist   <= 2'd1;
        need4 <= io_wdata[0];
      end else if (wr_even) begin
        if (io_wdata[3]) ocw3 <= {io_wdata[6], io_wdata[2:0]};
        else             ocw2 <= {io_wdata[7:5], io_wdata[2:0]};
      end else if (wr_odd) begin
        case (ist)
          2'd1: begin icw2 <= io_wdata[7:3]; ist <= 2'd2; end
          2'd2: begin icw3 <= io_wdata; ist <= need4 ? 2'd3 : 2'd0; end
          2'd3: begin icw4 <= {io_wdata[4], io_wdata[1]}; ist <= 2'd0; end
          default: ocw1 <= io_wdata;
        endcase
      end
    end
  end

  // interval timer shadows, one per counter
  for (genvar n = 0; n < 3; n++) begin : g_pit
    localparam logic [AW-1:0] DPORT = PIT + AW'(n);
    logic [5:0] st;
    logic [7:0] lo, hi;
    logic       tog;

    wire ctl = io_wr && io_addr == PIT + THREE && io_wdata[7:6] == 2'(n)
               && io_wdata[5:4] != 2'b00;
    wire dat = io_wr && io_addr == DPORT;

    always_ff @(posedge clk) begin
      if (rst) begin
        st <= '0; lo <= '0; hi <= '0; tog <= 1'b0;
      end else if (ctl) begin
        st  <= io_wdata[5:0];
        tog <= 1'b0;
      end else if (dat) begin
        case (st[5:4])
          2'b01: begin lo <= io_wdata; hi <= '0; end
          2'b10: begin hi <= io_wdata; lo <= '0; end
          2'b11: begin
            if (tog) hi <= io_wdata;
            else     lo <= io_wdata;
            tog <= ~tog;
          end
          default: ;
        endcase
      end
    end
  end

  logic [6:0] rtc_idx;
  always_ff @(posedge clk) begin
    if (rst) rtc_idx <= '0;
    else if (io_wr && io_addr == RTC) rtc_idx <= io_wdata[6:0];
  end

  // read side
  wire sel_pic = io_addr == PIC_M;
  wire sel_pit = io_addr == PIT;
  wire sel_c2  = io_addr == PIT + TWO;
  wire sel_rtc = io_addr == RTC;

  assign rd_hit = io_rd && alt_mode && (sel_pic || sel_pit || sel_c2 || sel_rtc);

  logic [3:0] cnt_pic;
  logic [2:0] cnt_pit;

  always_ff @(posedge clk) begin
    if (rst || !alt_mode) begin
      cnt_pic <= '0;
      cnt_pit <= '0;
    end else if (rd_hit) begin
      if (sel_pic) cnt_pic <= (cnt_pic == PIC_LAST) ? 4'd0 : cnt_pic + 4'd1;
      if (sel_pit) cnt_pit <= (cnt_pit == PIT_LAST) ? 3'd0 : cnt_pit + 3'd1;
    end
  end

  logic [7:0] pic_word [12];
  for (genvar c = 0; c < 2; c++) begin : g_pic_rd
    assign pic_word[6*c+0] = {g_pic[c].icw2, 3'b000};
    assign pic_word[6*c+1] = g_pic[c].icw3;
    assign pic_word[6*c+2] = {3'b000, g_pic[c].icw4[1], 2'b00, g_pic[c].icw4[0], 1'b0};
    assign pic_word[6*c+3] = g_pic[c].ocw1;
    assign pic_word[6*c+4] = {g_pic[c].ocw2[5:3], 2'b00, g_pic[c].ocw2[2:0]};
    assign pic_word[6*c+5] = {1'b0, g_pic[c].ocw3[3], g_pic[c].ocw3[3], 2'b01,
                              g_pic[c].ocw3[2:0]};
  end

  logic [7:0] pit_word;
  always_comb begin
    case (cnt_pit)
      3'd0:    pit_word = {2'b00, g_pit[0].st};
      3'd1:    pit_word = g_pit[0].lo;
      3'd2:    pit_word = g_pit[0].hi;
      3'd3:    pit_word = g_pit[1].lo;
      3'd4:    pit_word = g_pit[1].hi;
      3'd5:    pit_word = g_pit[2].lo;
      default: pit_word = g_pit[2].hi;
    endcase
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_hit) begin
      if (sel_pic)      rd_data = pic_word[cnt_pic];
      else if (sel_pit) rd_data = pit_word;
      else if (sel_c2)  rd_data = {2'b00, g_pit[2].st};
      else              rd_data = {1'b0, rtc_idx};
    end
  end

  // R10
  hit_needs_alt_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hit |-> alt_mode);

  // R10
  quiet_when_missed_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |-> rd_data == 8'h00);

  // R9
  seq_parked_chk: assert property (@(posedge clk) disable iff (rst)
    !alt_mode |=> (cnt_pic == 4'd0 && cnt_pit == 3'd0));

  // R1
  pic_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_pic <= PIC_LAST);

  // R4
  rtc_top_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && sel_rtc) |-> !rd_data[7]);

  // R5
  ocw3_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && sel_pic && (cnt_pic == 4'd5 || cnt_pic == 4'd11))
      |-> (rd_data[5] == rd_data[6] && rd_data[4:3] == 2'b01 && !rd_data[7]));

  // R3
  c2_status_top_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && sel_c2) |-> rd_data[7:6] == 2'b00);

  // R9
  pit_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && sel_pit && alt_mode && cnt_pit != PIT_LAST) |=>
      (!alt_mode || cnt_pit == $past(cnt_pit) + 3'd1));

endmodule

// File: tb/io_shadow_readback_tb.sv
module io_shadow_readback_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alt_mode = 1'b0;
  logic io_wr = 1'b0;
  logic io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic rd_hit;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  io_shadow_readback u_dut (
    .clk(clk), .rst(rst), .alt_mode(alt_mode), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .rd_hit(rd_hit), .rd_data(rd_data)
  );

  // op: 0 write, 1 read served, 2 mode on, 3 mode off, 4 read not served
  localparam int NV = 54;
  localparam logic [34:0] VEC [NV] = '{
    {3'd0, 16'h0020, 8'h11, 8'h00},  // R6 master ICW1, ICW4 wanted
    {3'd0, 16'h0021, 8'h0D, 8'h00},
    {3'd0, 16'h0021, 8'h04, 8'h00},
    {3'd0, 16'h0021, 8'hFF, 8'h00},
    {3'd0, 16'h0021, 8'hB8, 8'h00},  // OCW1
    {3'd0, 16'h0020, 8'h27, 8'h00},  // OCW2
    {3'd0, 16'h0020, 8'h4B, 8'h00},  // OCW3
    {3'd0, 16'h00A0, 8'h10, 8'h00},  // slave ICW1, no ICW4
    {3'd0, 16'h00A1, 8'h77, 8'h00},
    {3'd0, 16'h00A1, 8'h02, 8'h00},
    {3'd0, 16'h00A1, 8'h5A, 8'h00},  // goes to OCW1
    {3'd0, 16'h00A0, 8'hE3, 8'h00},
    {3'd0, 16'h00A0, 8'h0A, 8'h00},
    {3'd0, 16'h0043, 8'h34, 8'h00},  // R7 counter0 lo/hi
    {3'd0, 16'h0040, 8'h9C, 8'h00},  // R8
    {3'd0, 16'h0040, 8'h2E, 8'h00},
    {3'd0, 16'h0043, 8'h54, 8'h00},  // counter1 low only
    {3'd0, 16'h0041, 8'h12, 8'h00},
    {3'd0, 16'h0043, 8'hB6, 8'h00},  // counter2 lo/hi
    {3'd0, 16'h0042, 8'hA9, 8'h00},
    {3'd0, 16'h0042, 8'h04, 8'h00},
    {3'd0, 16'h0070, 8'h8D, 8'h00},
    {3'd2, 16'h0000, 8'h00, 8'h00},
    {3'd1, 16'h0020, 8'h00, 8'h08},  // R1 R5 ICW2 low bits zero
    {3'd1, 16'h0020, 8'h00, 8'h04},
    {3'd1, 16'h0020, 8'h00, 8'h12},  // R5 ICW4
    {3'd1, 16'h0020, 8'h00, 8'hB8},
    {3'd1, 16'h0020, 8'h00, 8'h27},
    {3'd1, 16'h0020, 8'h00, 8'h6B},  // R5 OCW3 mirror
    {3'd1, 16'h0020, 8'h00, 8'h70},
    {3'd1, 16'h0020, 8'h00, 8'h02},
    {3'd1, 16'h0020, 8'h00, 8'h00},  // slave ICW4 never written
    {3'd1, 16'h0020, 8'h00, 8'h5A},
    {3'd1, 16'h0020, 8'h00, 8'hE3},
    {3'd1, 16'h0020, 8'h00, 8'h0A},
    {3'd1, 16'h0020, 8'h00, 8'h08},  // R9 wrap
    {3'd1, 16'h0040, 8'h00, 8'h34},  // R2
    {3'd1, 16'h0040, 8'h00, 8'h9C},
    {3'd1, 16'h0040, 8'h00, 8'h2E},
    {3'd1, 16'h0040, 8'h00, 8'h12},
    {3'd1, 16'h0040, 8'h00, 8'h00},
    {3'd1, 16'h0040, 8'h00, 8'hA9},
    {3'd1, 16'h0040, 8'h00, 8'h04},
    {3'd1, 16'h0040, 8'h00, 8'h34},  // wrap
    {3'd1, 16'h0042, 8'h00, 8'h36},  // R3
    {3'd1, 16'h0042, 8'h00, 8'h36},
    {3'd1, 16'h0070, 8'h00, 8'h0D},  // R4
    {3'd4, 16'h0021, 8'h00, 8'h00},  // R10 unlisted port
    {3'd3, 16'h0000, 8'h00, 8'h00},
    {3'd2, 16'h0000, 8'h00, 8'h00},
    {3'd1, 16'h0040, 8'h00, 8'h34},  // R9 counter back at start
    {3'd1, 16'h0020, 8'h00, 8'h08},
    {3'd3, 16'h0000, 8'h00, 8'h00},
    {3'd4, 16'h0020, 8'h00, 8'h00}   // R10 mode off
  };

  function automatic string tag_of(logic [15:0] a, bit served);
    if (!served) return "R10";
    case (a)
      16'h0020: return "R1";
      16'h0040: return "R2";
      16'h0042: return "R3";
      default:  return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp,
                       logic hit_act, logic hit_exp);
    checks++;
    if (act !== exp || hit_act !== hit_exp) begin
      failures++;
      $display("FAIL %s: data=%02h hit=%0b expected data=%02h hit=%0b",
               req, act, hit_act, exp, hit_exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(posedge clk); #0.5;
    io_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, logic [7:0] exp, logic hexp, string req);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    #1;
    check(req, rd_data, exp, rd_hit, hexp);
    @(posedge clk); #0.5;
    io_rd = 1'b0;
  endtask

  task automatic set_mode(logic m);
    @(negedge clk);
    alt_mode = m;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #0.5 rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][34:32])
        3'd0: wr(VEC[i][31:16], VEC[i][15:8]);
        3'd1: rd(VEC[i][31:16], VEC[i][7:0], 1'b1, tag_of(VEC[i][31:16], 1'b1));
        3'd2: set_mode(1'b1);
        3'd3: set_mode(1'b0);
        default: rd(VEC[i][31:16], 8'h00, 1'b0, "R10");
      endcase
    end

    // R11 reset clears shadows and counters
    set_mode(1'b1);
    rd(16'h0020, 8'h08, 1'b1, "R1");
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    rd(16'h0020, 8'h00, 1'b1, "R11");
    rd(16'h0040, 8'h00, 1'b1, "R11");
    rd(16'h0042, 8'h00, 1'b1, "R11");
    rd(16'h0070, 8'h00, 1'b1, "R11");

    // R8 access modes, written while mode is on (R10 capture continues)
    wr(16'h0043, 8'h60);  // counter1 high only
    wr(16'h0041, 8'h55);
    wr(16'h0043, 8'h34);
    wr(16'h0040, 8'h11);
    wr(16'h0043, 8'h34);  // toggle restarts
    wr(16'h0040, 8'h22);
    wr(16'h0040, 8'h33);
    wr(16'h0043, 8'h00);  // R7 latch command, no change
    wr(16'h0043, 8'hC2);  // R7 select 3, no change
    wr(16'h0020, 8'h10);  // R6 re-init master without ICW4
    wr(16'h0021, 8'hF8);
    wr(16'h0021, 8'h00);
    wr(16'h0021, 8'h3C);  // becomes OCW1
    set_mode(1'b0);
    set_mode(1'b1);
    rd(16'h0040, 8'h34, 1'b1, "R7");
    rd(16'h0040, 8'h22, 1'b1, "R8");
    rd(16'h0040, 8'h33, 1'b1, "R8");
    rd(16'h0040, 8'h00, 1'b1, "R8");
    rd(16'h0040, 8'h55, 1'b1, "R8");
    rd(16'h0020, 8'hF8, 1'b1, "R6");
    rd(16'h0020, 8'h00, 1'b1, "R6");
    rd(16'h0020, 8'h00, 1'b1, "R6");
    rd(16'h0020, 8'h3C, 1'b1, "R6");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule